// File: doc/BRIEF.md
# Backscatter Line Encoder (FM0 and Miller)

This block turns a tag reply into the baseband waveform that drives the backscatter modulator. A reply is started with a one-cycle request. The request carries the coding mode, the Miller subcarrier multiple, the extended-preamble flag, a link-rate divider value, a payload word and its length in bits. The block then sends a leading run of zero symbols where the mode calls for one, then the protocol preamble, then the payload bits, and last a closing dummy 1 symbol. After that it drops the line low and raises a one-cycle completion pulse.

Each symbol is formed as a pair of half-symbol levels by a level-tracking coder. A serializer shifts the pair out on one output line, one chip at a time. In FM0 a half-symbol is one chip long. In Miller mode a half-symbol spans M chips, and the baseband level is mixed with a square subcarrier. The chip rate is a clock-enable division of the core clock. This covers the full range of link rates from one engine.

Top module: `backscatter_enc`

## Requirements
- R1: Out of reset, and whenever no reply is in progress, `tx_o`, `busy_o` and `done_o` are 0.
- R2: FM0 mode (`miller_i`=0): every symbol starts by inverting the previous level, and a 0 symbol also inverts at mid-symbol. The line rests at 0 before a reply, so the first half-symbol is 1.
- R3: The FM0 preamble is the symbol sequence 1,0,1,0,V,1. V is a 1 symbol whose starting inversion is left out. With `trext_i`=1, twelve 0 symbols come before it; with `trext_i`=0, none do.
- R4: Miller mode (`miller_i`=1): the baseband level inverts at mid-symbol for a 1. At a symbol start it inverts only when both this symbol and the previous one are 0. The level starts at 0 and the reply starts as if a 1 came before it.
- R5: The Miller preamble is a pilot of 0 symbols followed by 0,1,0,1,1,1. The pilot is 4 symbols long with `trext_i`=0 and 20 with `trext_i`=1.
- R6: `msel_i` values 0,1,2,3 select M = 1,2,4,8. In Miller mode each half-symbol lasts M chips. For M>1, chip k (counted from 0 within the half-symbol) carries the baseband level inverted when k is odd.
- R7: Payload bits follow the preamble, sent from `payload_i[len-1]` down to `payload_i[0]`. A length of 0 sends no payload bits. A length above PAY_W is treated as PAY_W.
- R8: After the payload, a 1 symbol ends the reply. `busy_o` then falls and `done_o` is high for exactly one cycle; one cycle later `tx_o` is 0.
- R9: Each chip holds `tx_o` for `rate_div_i`+1 clock cycles. The first chip appears on `tx_o` one cycle after the edge that accepts `start_i`.
- R10: `start_i` and configuration changes while `busy_o`=1 have no effect on the reply in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Reply request, accepted when idle |
| miller_i | input | 1 | 0 selects FM0, 1 selects Miller |
| msel_i | input | MSEL_W | Miller subcarrier multiple select (M = 2^msel) |
| trext_i | input | 1 | Extended preamble flag |
| rate_div_i | input | DIV_W | Chip duration minus one, in clock cycles |
| len_i | input | LEN_W | Payload length in bits |
| payload_i | input | PAY_W | Payload bits, highest used bit first |
| tx_o | output | 1 | Serial backscatter waveform |
| busy_o | output | 1 | Reply in progress |
| done_o | output | 1 | One-cycle pulse at end of reply |

## Verification
The hardest situation to reach is the FM0 violation symbol V. Its effect only shows as a missing inversion, relative to a level that depends on every earlier symbol and on whether the twelve leading zeros were sent. The bench sweeps both coding modes, every subcarrier multiple, both preamble options, payload lengths of 0, 5, 16 and an over-long 20, and three divider values. For each reply it builds the full expected chip stream arithmetically and compares every chip. On some replies it pulses `start_i` with a changed configuration in mid-reply, and checks that the stream is unchanged.

// File: rtl/bs_pkg.sv
`timescale 1ns/1ps
package bs_pkg;
  typedef enum logic [1:0] {
    SEG_PILOT = 2'd0,
    SEG_PRE   = 2'd1,
    SEG_DATA  = 2'd2,
    SEG_DUMMY = 2'd3
  } seg_t;

  localparam int FM0_PILOT       = 12;
  localparam int MIL_PILOT_SHORT = 4;
  localparam int MIL_PILOT_LONG  = 20;
  localparam int PRE_LEN         = 6;
  // preamble symbols, sent from bit 5 down to bit 0
  localparam logic [5:0] FM0_PRE = 6'b101011;
  localparam logic [5:0] MIL_PRE = 6'b010111;
  // down-counter value at which the FM0 violation symbol is sent
  localparam int FM0_VIOL_POS    = 1;
endpackage

// File: rtl/bs_rate_div.sv
`timescale 1ns/1ps
module bs_rate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = en & (cnt_q == div_val);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || tick) cnt_d = '0;
    else if (en)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bs_sym_seq.sv
`timescale 1ns/1ps
module bs_sym_seq import bs_pkg::*; #(
  parameter int PAY_W = 16,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic             miller_i,
  input  logic             trext_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [PAY_W-1:0] payload_i,
  input  logic             miller_q,
  output logic             sym_bit,
  output logic             sym_viol,
  output logic             sym_last
);
  localparam int MAXS  = (PAY_W > MIL_PILOT_LONG) ? PAY_W : MIL_PILOT_LONG;
  localparam int CNT_W = $clog2(MAXS + 1);
  localparam int IDX_W = (PAY_W > 1) ? $clog2(PAY_W) : 1;

  seg_t             seg_q, seg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, pilot_n;
  logic [PAY_W-1:0] pay_q, pay_d;
  logic [LEN_W-1:0] len_q, len_d, len_eff;
  logic [5:0]       pat;

  always_comb begin
    if (miller_i) pilot_n = trext_i ? CNT_W'(MIL_PILOT_LONG) : CNT_W'(MIL_PILOT_SHORT);
    else          pilot_n = trext_i ? CNT_W'(FM0_PILOT) : '0;
    len_eff = (len_i > LEN_W'(PAY_W)) ? LEN_W'(PAY_W) : len_i;
  end

  always_comb begin
    seg_d = seg_q;
    cnt_d = cnt_q;
    pay_d = pay_q;
    len_d = len_q;
    if (load) begin
      pay_d = payload_i;
      len_d = len_eff;
      if (pilot_n != '0) begin
        seg_d = SEG_PILOT;
        cnt_d = pilot_n - 1'b1;
      end else begin
        seg_d = SEG_PRE;
        cnt_d = CNT_W'(PRE_LEN - 1);
      end
    end else if (adv) begin
      case (seg_q)
        SEG_PILOT: begin
          if (cnt_q == '0) begin
            seg_d = SEG_PRE;
            cnt_d = CNT_W'(PRE_LEN - 1);
          end else cnt_d = cnt_q - 1'b1;
        end
        SEG_PRE: begin
          if (cnt_q == '0) begin
            seg_d = (len_q == '0) ? SEG_DUMMY : SEG_DATA;
            cnt_d = CNT_W'(len_q) - 1'b1;
          end else cnt_d = cnt_q - 1'b1;
        end
        SEG_DATA: begin
          if (cnt_q == '0) seg_d = SEG_DUMMY;
          else             cnt_d = cnt_q - 1'b1;
        end
        default: seg_d = SEG_DUMMY;
      endcase
    end
  end

  always_comb begin
    pat      = miller_q ? MIL_PRE : FM0_PRE;
    sym_bit  = 1'b1;
    sym_viol = 1'b0;
    case (seg_q)
      SEG_PILOT: sym_bit = 1'b0;
      SEG_PRE: begin
        sym_bit  = pat[cnt_q[2:0]];
        sym_viol = !miller_q && (cnt_q == CNT_W'(FM0_VIOL_POS));
      end
      SEG_DATA:  sym_bit = pay_q[cnt_q[IDX_W-1:0]];
      default:   sym_bit = 1'b1;
    endcase
    sym_last = (seg_q == SEG_DUMMY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_DUMMY;
      cnt_q <= '0;
      pay_q <= '0;
      len_q <= '0;
    end else begin
      seg_q <= seg_d;
      cnt_q <= cnt_d;
      pay_q <= pay_d;
      len_q <= len_d;
    end
  end

  // R7
  seg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (seg_q >= $past(seg_q)));
endmodule

// File: rtl/bs_pair_coder.sv
`timescale 1ns/1ps
module bs_pair_coder (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  input  logic miller,
  input  logic sym_bit,
  input  logic sym_viol,
  output logic h0,
  output logic h1
);
  logic lvl_q, lvl_d, prev_q, prev_d;

  always_comb begin
    if (miller) begin
      h0 = (!sym_bit && !prev_q) ? !lvl_q : lvl_q;
      h1 = sym_bit ? !h0 : h0;
    end else begin
      h0 = sym_viol ? lvl_q : !lvl_q;
      h1 = sym_bit ? h0 : !h0;
    end
  end

  always_comb begin
    lvl_d  = lvl_q;
    prev_d = prev_q;
    if (load) begin
      lvl_d  = 1'b0;
      prev_d = 1'b1;
    end else if (adv) begin
      lvl_d  = h1;
      prev_d = sym_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      lvl_q  <= lvl_d;
      prev_q <= prev_d;
    end
  end

  // R3
  fm0_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !miller && !load) |=> (sym_viol ? (h0 == $past(h1)) : (h0 != $past(h1))));
endmodule

// File: rtl/backscatter_enc.sv
`timescale 1ns/1ps
module backscatter_enc import bs_pkg::*; #(
  parameter int PAY_W  = 16,
  parameter int DIV_W  = 8,
  parameter int MSEL_W = 2,
  parameter int LEN_W  = $clog2(PAY_W + 1)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              miller_i,
  input  logic [MSEL_W-1:0] msel_i,
  input  logic              trext_i,
  input  logic [DIV_W-1:0]  rate_div_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PAY_W-1:0]  payload_i,
  output logic              tx_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int K_W = (1 << MSEL_W) - 1;

  logic [1:0]        rsync_q;
  logic              rst_n;
  logic              busy_q, busy_d, done_q, done_d, tx_q, tx_d;
  logic              half_q, half_d;
  logic [K_W-1:0]    k_q, k_d, cph_m1;
  logic              miller_q, miller_d, trext_q, trext_d;
  logic [MSEL_W-1:0] msel_q, msel_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              load, tick, k_end, chip_end, sym_adv, finish, chip;
  logic              sym_bit, sym_viol, sym_last, h0, h1;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  bs_rate_div #(.DIV_W(DIV_W)) rate_i (
    .clk(clk), .rst_n(rst_n), .en(busy_q), .clr(load),
    .div_val(div_q), .tick(tick)
  );

  bs_sym_seq #(.PAY_W(PAY_W), .LEN_W(LEN_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(sym_adv),
    .miller_i(miller_i), .trext_i(trext_i), .len_i(len_i),
    .payload_i(payload_i), .miller_q(miller_q),
    .sym_bit(sym_bit), .sym_viol(sym_viol), .sym_last(sym_last)
  );

  bs_pair_coder coder_i (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(sym_adv),
    .miller(miller_q), .sym_bit(sym_bit), .sym_viol(sym_viol),
    .h0(h0), .h1(h1)
  );

  always_comb begin
    load     = start_i & ~busy_q;
    cph_m1   = miller_q ? ((K_W'(1) << msel_q) - K_W'(1)) : '0;
    k_end    = (k_q == cph_m1);
    chip_end = tick & k_end;
    sym_adv  = chip_end & half_q;
    finish   = sym_adv & sym_last;
    chip     = (half_q ? h1 : h0) ^ (miller_q & k_q[0]);
  end

  always_comb begin
    busy_d   = busy_q;
    half_d   = half_q;
    k_d      = k_q;
    miller_d = miller_q;
    msel_d   = msel_q;
    trext_d  = trext_q;
    div_d    = div_q;
    if (load) begin
      busy_d   = 1'b1;
      half_d   = 1'b0;
      k_d      = '0;
      miller_d = miller_i;
      msel_d   = msel_i;
      trext_d  = trext_i;
      div_d    = rate_div_i;
    end else begin
      if (finish)   busy_d = 1'b0;
      if (tick)     k_d    = k_end ? '0 : k_q + 1'b1;
      if (chip_end) half_d = ~half_q;
    end
    tx_d   = busy_q & chip;
    done_d = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      tx_q     <= 1'b0;
      half_q   <= 1'b0;
      k_q      <= '0;
      miller_q <= 1'b0;
      msel_q   <= '0;
      trext_q  <= 1'b0;
      div_q    <= '0;
    end else begin
      busy_q   <= busy_d;
      done_q   <= done_d;
      tx_q     <= tx_d;
      half_q   <= half_d;
      k_q      <= k_d;
      miller_q <= miller_d;
      msel_q   <= msel_d;
      trext_q  <= trext_d;
      div_q    <= div_d;
    end
  end

  assign tx_o   = tx_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !tx_q);
  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(miller_q) && $stable(msel_q) && $stable(trext_q) && $stable(div_q)));
  // R6
  chip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (k_q <= cph_m1));
endmodule

// File: tb/backscatter_enc_tb_top.sv
`timescale 1ns/1ps
module backscatter_enc_tb_top;
  localparam int PAY_W = 16;
  localparam int LEN_W = 5;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             start_i, miller_i, trext_i;
  logic [1:0]       msel_i;
  logic [DIV_W-1:0] rate_div_i;
  logic [LEN_W-1:0] len_i;
  logic [PAY_W-1:0] payload_i;
  logic             tx_o, busy_o, done_o;

  int total = 0;
  int fails = 0;
  logic exp_c [0:1023];
  int   n_exp;

  always #2.5 clk = ~clk;

  backscatter_enc #(.PAY_W(PAY_W), .DIV_W(DIV_W), .MSEL_W(2), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_ni(rst_ni), .start_i(start_i), .miller_i(miller_i),
    .msel_i(msel_i), .trext_i(trext_i), .rate_div_i(rate_div_i),
    .len_i(len_i), .payload_i(payload_i),
    .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic build(input logic mil, input logic [1:0] ms, input logic tx,
                       input int ln, input logic [PAY_W-1:0] pay);
    logic sb [0:63];
    logic sv [0:63];
    int ns, np, eff, cph;
    logic lvl, prev, a, b, h;
    logic [5:0] pre;
    ns  = 0;
    np  = mil ? (tx ? 20 : 4) : (tx ? 12 : 0);
    pre = mil ? 6'b010111 : 6'b101011;
    for (int i = 0; i < np; i++) begin sb[ns] = 1'b0; sv[ns] = 1'b0; ns++; end
    for (int i = 0; i < 6; i++) begin
      sb[ns] = pre[5-i]; sv[ns] = !mil && (i == 4); ns++;
    end
    eff = (ln > PAY_W) ? PAY_W : ln;
    for (int i = eff - 1; i >= 0; i--) begin sb[ns] = pay[i]; sv[ns] = 1'b0; ns++; end
    sb[ns] = 1'b1; sv[ns] = 1'b0; ns++;
    cph   = mil ? (1 << ms) : 1;
    lvl   = 1'b0;
    prev  = 1'b1;
    n_exp = 0;
    for (int s = 0; s < ns; s++) begin
      if (mil) begin
        a = (!sb[s] && !prev) ? !lvl : lvl;
        b = sb[s] ? !a : a;
      end else begin
        a = sv[s] ? lvl : !lvl;
        b = sb[s] ? a : !a;
      end
      for (int hf = 0; hf < 2; hf++) begin
        h = (hf == 0) ? a : b;
        for (int k = 0; k < cph; k++) begin
          exp_c[n_exp] = h ^ (mil && (k % 2 == 1));
          n_exp++;
        end
      end
      lvl  = b;
      prev = sb[s];
    end
  endtask

  task automatic run_frame(input logic mil, input logic [1:0] ms, input logic tx,
                           input int ln, input logic [PAY_W-1:0] pay,
                           input int rate, input bit inj);
    int mism, first_j, dcnt;
    logic first_a, first_e;
    string tag;
    build(mil, ms, tx, ln, pay);
    @(negedge clk);
    miller_i = mil; msel_i = ms; trext_i = tx; len_i = LEN_W'(ln);
    payload_i = pay; rate_div_i = DIV_W'(rate); start_i = 1'b1;
    @(posedge clk);
    @(posedge clk);
    mism = 0; first_j = -1; first_a = 1'b0; first_e = 1'b0;
    for (int j = 0; j < n_exp; j++) begin
      @(negedge clk);
      if (j == 0) begin
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R9 busy after start", int'(busy_o), 1);
      end
      if (tx_o !== exp_c[j]) begin
        if (first_j < 0) begin first_j = j; first_a = tx_o; first_e = exp_c[j]; end
        mism++;
      end
      if (inj && j == 2) begin
        start_i = 1'b1; miller_i = !mil; trext_i = !tx; msel_i = ~ms;
        len_i = 5'd3; payload_i = ~pay; rate_div_i = DIV_W'(rate + 1);
      end
      if (j != n_exp - 1) begin
        repeat (rate + 1) @(posedge clk);
        start_i = 1'b0;
      end
    end
    tag = mil ? "R4 R5 R6 R7 R9 waveform" : "R2 R3 R7 R9 waveform";
    if (inj) tag = {tag, " R10"};
    if (mism != 0)
      $display("FAIL %s chip %0d of %0d: actual=%0d expected=%0d",
               tag, first_j, n_exp, first_a, first_e);
    total++;
    if (mism != 0) fails++;
    dcnt = 0;
    for (int t = 0; t < rate + 3; t++) begin
      if (t != 0) @(negedge clk);
      if (done_o === 1'b1) dcnt++;
    end
    chk(dcnt == 1, "R8 done pulse count", dcnt, 1);
    @(negedge clk);
    chk(tx_o === 1'b0 && busy_o === 1'b0, "R1 R8 idle after reply",
        int'({busy_o, tx_o}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int lens [4];
    logic [PAY_W-1:0] pay;
    int idx;
    lens[0] = 0; lens[1] = 5; lens[2] = 16; lens[3] = 20;
    rst_ni = 1'b0; start_i = 1'b0; miller_i = 1'b0; msel_i = 2'd0; trext_i = 1'b0;
    rate_div_i = '0; len_i = '0; payload_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tx_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1 reset state",
        int'({done_o, busy_o, tx_o}), 0);
    idx = 0;
    for (int mi = 0; mi < 5; mi++) begin
      for (int tx = 0; tx < 2; tx++) begin
        for (int li = 0; li < 4; li++) begin
          pay = 16'hB38E ^ PAY_W'(idx * 16'h1F3);
          run_frame(mi != 0, (mi == 0) ? 2'd0 : 2'(mi - 1), tx[0], lens[li], pay,
                    (mi + li + tx) % 3, li == 1);
          idx++;
        end
      end
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule